// File: doc/BRIEF.md
# Time-Shared Three-Level Gaussian Pyramid Engine

This block turns a raster stream of 8-bit source pixels into the two smaller levels of a Gaussian pyramid. The source image is the finest level, G0. Each coarser level is made by smoothing the level above it with a 3x3 binomial kernel and then keeping only the even rows and even columns. Border pixels are replicated, so a window near an edge reuses the nearest pixel inside the image. G1 is produced from G0 and G2 from G1. Both results leave on one valid/ready output stream. Each beat carries a level tag and an end-of-frame flag.

All smoothing is done by one convolution unit. A fixed work cycle of 21 clock slots divides that unit among the levels. One slot is reserved for the coarsest level, four slots serve windows taken from the G1 buffer, and sixteen serve windows taken from the G0 buffer. Each buffer level keeps a four-row ring of its own pixels. A timing multiplexer connects the window of the level that owns the current slot to the shared unit. A slot does no work when its level has no complete window, when the downstream buffer is full, or when the output register is busy. G1 pixels stay on chip in their own ring. They are emitted once and are never read back from outside.

Top module: `tspyr_engine`

## Requirements
- R1: For every even row r and even column c of the 16x16 source, a beat with tag 1 carries (sum of w(dr)*w(dc)*G0[clamp(r+dr)][clamp(c+dc)]) >> 4, where dr and dc run over -1..1, w(0)=2, w(+-1)=1, and clamp limits the index to the image.
- R2: Tag 2 beats carry the same filter applied to the 8x8 G1 image at its even positions, which gives a 4x4 G2 image.
- R3: The tag is 2'd1 for G1 and 2'd2 for G2. No other tag value appears. Within one level, beats leave in raster order.
- R4: o_last is high on the 64th G1 beat and on the 16th G2 beat of each frame, and low on every other beat.
- R5: While o_valid is high and o_ready is low, o_valid, o_pix, o_level and o_last hold their values.
- R6: A source pixel is taken only on a clock edge with i_valid and i_ready both high. Idle gaps on the input do not change the results.
- R7: A slot counter starts at 0 on the first clock edge after reset is released and counts modulo 21. A tag 2 beat is loaded only at an edge whose slot is 1 to 4. A tag 1 beat is loaded only at an edge whose slot is 5 to 20. Slot 0 never loads a beat.
- R8: Each frame gives exactly 64 tag 1 beats and 16 tag 2 beats, and nothing else is emitted.
- R9: Frames may follow one another without a pause. Each frame is filtered on its own.
- R10: After reset, o_valid is low and i_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Source pixel valid |
| i_ready | output | 1 | Engine can take a source pixel |
| i_pix | input | PIX_W | Source pixel, raster order |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Consumer takes the beat |
| o_pix | output | PIX_W | Filtered, downsampled pixel |
| o_level | output | 2 | Level tag (1 = G1, 2 = G2) |
| o_last | output | 1 | Final pixel of this level's frame |

## Verification
A corrupted row pointer or window index in a level ring shows up within the first kept row of that level. It appears as a wrong pixel value, first in the border beats where replication is used. A stuck or skipped job pointer makes the per-level beat count drift, so o_last lands on the wrong beat or the frame never completes. A damaged slot counter or timing multiplexer shows on the first beat of the affected level. Either the beat carries a value filtered from the other level's window, or it is loaded in a slot that belongs to the other level.

// File: rtl/tspyr_pkg.sv
package tspyr_pkg;

  // level tags as carried on the output stream
  typedef enum logic [1:0] {
    LVL_G0 = 2'd0,
    LVL_G1 = 2'd1,
    LVL_G2 = 2'd2
  } lvl_e;

  localparam int NUM_LEVELS = 3;
  localparam int BUF_LEVELS = NUM_LEVELS - 1;   // levels that own a ring buffer
  localparam int KTAPS      = 9;                // 3x3 window
  localparam int KSHIFT     = 4;                // kernel sum is 16
  localparam int RING_ROWS  = 4;
  localparam int RSEL_W     = $clog2(RING_ROWS);

  // binomial weight of tap idx (row-major 3x3) expressed as a left shift
  function automatic int tap_shift(input int idx);
    int s;
    s = 0;
    if ((idx / 3) == 1) s = s + 1;
    if ((idx % 3) == 1) s = s + 1;
    return s;
  endfunction

endpackage

// File: rtl/tspyr_slot_sched.sv
module tspyr_slot_sched
  import tspyr_pkg::*;
#(
  parameter int SLOTS_G2 = 1,
  parameter int SLOTS_G1 = 4,
  parameter int SLOTS_G0 = 16
) (
  input  logic clk,
  input  logic rst_n,
  output lvl_e slot_lvl
);

  localparam int TOTAL = SLOTS_G2 + SLOTS_G1 + SLOTS_G0;
  localparam int SW    = $clog2(TOTAL);
  localparam logic [SW-1:0] LAST_SLOT = SW'(TOTAL - 1);
  localparam logic [SW-1:0] G1_START  = SW'(SLOTS_G2);
  localparam logic [SW-1:0] G0_START  = SW'(SLOTS_G2 + SLOTS_G1);

  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == LAST_SLOT) slot_d = '0;
    else                     slot_d = slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  always_comb begin
    if (slot_q < G1_START)      slot_lvl = LVL_G2;
    else if (slot_q < G0_START) slot_lvl = LVL_G1;
    else                        slot_lvl = LVL_G0;
  end

endmodule

// File: rtl/tspyr_level_buf.sv
module tspyr_level_buf
  import tspyr_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LW    = 16,
  parameter int LH    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_valid,
  input  logic [PIX_W-1:0]              push_pix,
  output logic                          push_ready,
  output logic                          job_avail,
  output logic [KTAPS-1:0][PIX_W-1:0]   job_win,
  output logic                          job_keep,
  output logic                          job_final,
  input  logic                          job_take
);

  localparam int CW = $clog2(LW);
  localparam int RW = $clog2(LH + 3);
  localparam logic [RW-1:0] ROWS   = RW'(LH);
  localparam logic [RW-1:0] LAST_R = RW'(LH - 1);
  localparam logic [RW-1:0] KEEP_R = RW'(LH - 2);
  localparam logic [RW-1:0] AHEAD  = RW'(2);
  localparam logic [CW-1:0] LAST_C = CW'(LW - 1);
  localparam logic [CW-1:0] KEEP_C = CW'(LW - 2);

  logic [PIX_W-1:0] ring [RING_ROWS][LW];

  logic [RW-1:0] wr_row_q, wr_row_d, jr_q, jr_d;
  logic [CW-1:0] wr_col_q, wr_col_d, jc_q, jc_d;
  logic [RW-1:0] need_rows, jr_m1, jr_p1;
  logic [CW-1:0] jc_m1, jc_p1;
  logic          push_fire;

  logic [RSEL_W-1:0] rsel [3];
  logic [CW-1:0]     csel [3];

  // rows complete needed before the window centred on row jr is whole
  assign need_rows  = (jr_q == LAST_R) ? ROWS : (jr_q + AHEAD);
  assign job_avail  = (wr_row_q >= need_rows);
  // writer may run two rows ahead of the job row: the ring slot it fills
  // never holds rows jr-1..jr+1
  assign push_ready = (wr_row_q < ROWS) && (wr_row_q <= (jr_q + AHEAD));
  assign push_fire  = push_valid && push_ready;

  assign job_keep  = !jr_q[0] && !jc_q[0];
  assign job_final = (jr_q == KEEP_R) && (jc_q == KEEP_C);

  always_comb begin
    wr_row_d = wr_row_q;
    wr_col_d = wr_col_q;
    jr_d     = jr_q;
    jc_d     = jc_q;
    if (push_fire) begin
      if (wr_col_q == LAST_C) begin
        wr_col_d = '0;
        wr_row_d = wr_row_q + RW'(1);
      end else begin
        wr_col_d = wr_col_q + CW'(1);
      end
    end
    if (job_take) begin
      if (jc_q == LAST_C) begin
        jc_d = '0;
        if (jr_q == LAST_R) begin
          // frame complete: rewind for the next frame
          jr_d     = '0;
          wr_row_d = '0;
          wr_col_d = '0;
        end else begin
          jr_d = jr_q + RW'(1);
        end
      end else begin
        jc_d = jc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_row_q <= '0;
      wr_col_q <= '0;
      jr_q     <= '0;
      jc_q     <= '0;
    end else begin
      wr_row_q <= wr_row_d;
      wr_col_q <= wr_col_d;
      jr_q     <= jr_d;
      jc_q     <= jc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) ring[wr_row_q[RSEL_W-1:0]][wr_col_q] <= push_pix;
  end

  // window gather with edge replication
  assign jr_m1 = jr_q - RW'(1);
  assign jr_p1 = jr_q + RW'(1);
  assign jc_m1 = jc_q - CW'(1);
  assign jc_p1 = jc_q + CW'(1);

  always_comb begin
    rsel[0] = (jr_q == '0)     ? jr_q[RSEL_W-1:0] : jr_m1[RSEL_W-1:0];
    rsel[1] = jr_q[RSEL_W-1:0];
    rsel[2] = (jr_q == LAST_R) ? jr_q[RSEL_W-1:0] : jr_p1[RSEL_W-1:0];
    csel[0] = (jc_q == '0)     ? jc_q : jc_m1;
    csel[1] = jc_q;
    csel[2] = (jc_q == LAST_C) ? jc_q : jc_p1;
  end

  for (genvar dr = 0; dr < 3; dr++) begin : g_row
    for (genvar dc = 0; dc < 3; dc++) begin : g_col
      assign job_win[dr*3+dc] = ring[rsel[dr]][csel[dc]];
    end
  end

endmodule

// File: rtl/tspyr_conv_pe.sv
module tspyr_conv_pe
  import tspyr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [KTAPS-1:0][PIX_W-1:0] win,
  output logic [PIX_W-1:0]            pix
);

  localparam int ACC_W = PIX_W + KSHIFT;

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < KTAPS; i++) begin
      acc = acc + (ACC_W'(win[i]) << tap_shift(i));
    end
  end

  assign pix = acc[ACC_W-1:KSHIFT];

endmodule

// File: rtl/tspyr_engine.sv
module tspyr_engine
  import tspyr_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 16,
  parameter int SLOTS_G2 = 1,
  parameter int SLOTS_G1 = 4,
  parameter int SLOTS_G0 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_valid,
  output logic             i_ready,
  input  logic [PIX_W-1:0] i_pix,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [PIX_W-1:0] o_pix,
  output logic [1:0]       o_level,
  output logic             o_last
);

  lvl_e slot_lvl;

  logic [BUF_LEVELS-1:0] avail_v, keep_v, final_v, take_v, push_valid_v, push_ready_v;
  logic [PIX_W-1:0]                  push_pix_v [BUF_LEVELS];
  logic [KTAPS-1:0][PIX_W-1:0]       win_v      [BUF_LEVELS];
  logic [KTAPS-1:0][PIX_W-1:0]       pe_win;
  logic [PIX_W-1:0]                  pe_pix;

  logic             fire0, fire1, out_free, load, load_last;
  lvl_e             load_lvl;
  logic             ov_q, ov_d, last_q, last_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  lvl_e             lvl_q, lvl_d;

  tspyr_slot_sched #(
    .SLOTS_G2 (SLOTS_G2),
    .SLOTS_G1 (SLOTS_G1),
    .SLOTS_G0 (SLOTS_G0)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_lvl (slot_lvl)
  );

  for (genvar g = 0; g < BUF_LEVELS; g++) begin : g_lvl
    tspyr_level_buf #(
      .PIX_W (PIX_W),
      .LW    (IMG_W >> g),
      .LH    (IMG_H >> g)
    ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid_v[g]),
      .push_pix   (push_pix_v[g]),
      .push_ready (push_ready_v[g]),
      .job_avail  (avail_v[g]),
      .job_win    (win_v[g]),
      .job_keep   (keep_v[g]),
      .job_final  (final_v[g]),
      .job_take   (take_v[g])
    );
  end

  // timing multiplexer: the slot owner's window drives the shared unit
  assign pe_win = (slot_lvl == LVL_G1) ? win_v[1] : win_v[0];

  tspyr_conv_pe #(
    .PIX_W (PIX_W)
  ) u_pe (
    .win (pe_win),
    .pix (pe_pix)
  );

  assign out_free = !ov_q || o_ready;

  always_comb begin
    fire0 = (slot_lvl == LVL_G0) && avail_v[0] &&
            (!keep_v[0] || (out_free && push_ready_v[1]));
    fire1 = (slot_lvl == LVL_G1) && avail_v[1] &&
            (!keep_v[1] || out_free);
    take_v[0] = fire0;
    take_v[1] = fire1;
    load      = (fire0 && keep_v[0]) || (fire1 && keep_v[1]);
    load_lvl  = fire1 ? LVL_G2 : LVL_G1;
    load_last = fire1 ? final_v[1] : final_v[0];
  end

  assign push_valid_v[0] = i_valid;
  assign push_pix_v[0]   = i_pix;
  assign push_valid_v[1] = fire0 && keep_v[0];
  assign push_pix_v[1]   = pe_pix;
  assign i_ready         = push_ready_v[0];

  // output register next state
  always_comb begin
    ov_d   = ov_q;
    pix_d  = pix_q;
    lvl_d  = lvl_q;
    last_d = last_q;
    if (load) begin
      ov_d   = 1'b1;
      pix_d  = pe_pix;
      lvl_d  = load_lvl;
      last_d = load_last;
    end else if (o_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      pix_q  <= '0;
      lvl_q  <= LVL_G0;
      last_q <= 1'b0;
    end else begin
      ov_q   <= ov_d;
      pix_q  <= pix_d;
      lvl_q  <= lvl_d;
      last_q <= last_d;
    end
  end

  assign o_valid = ov_q;
  assign o_pix   = pix_q;
  assign o_level = lvl_q;
  assign o_last  = last_q;

endmodule

// File: rtl/tspyr_engine_chk.sv
module tspyr_engine_chk
  import tspyr_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int IMG_W = 16,
  parameter int IMG_H = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             o_valid,
  input logic             o_ready,
  input logic [PIX_W-1:0] o_pix,
  input logic [1:0]       o_level,
  input logic             o_last,
  input logic [1:0]       slot_lvl,
  input logic             load,
  input logic [1:0]       load_lvl
);

  localparam int N1  = (IMG_W / 2) * (IMG_H / 2);
  localparam int N2  = (IMG_W / 4) * (IMG_H / 4);
  localparam int C1W = $clog2(N1);
  localparam int C2W = $clog2(N2);
  localparam logic [C1W-1:0] END1 = C1W'(N1 - 1);
  localparam logic [C2W-1:0] END2 = C2W'(N2 - 1);

  logic [C1W-1:0] cnt1;
  logic [C2W-1:0] cnt2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt1 <= '0;
      cnt2 <= '0;
    end else if (o_valid && o_ready) begin
      if (o_level == 2'd1) cnt1 <= (cnt1 == END1) ? '0 : cnt1 + C1W'(1);
      if (o_level == 2'd2) cnt2 <= (cnt2 == END2) ? '0 : cnt2 + C2W'(1);
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_pix) && $stable(o_level) && $stable(o_last)));

  p_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_level == 2'd1 || o_level == 2'd2));

  p_last_g1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_level == 2'd1) |-> (o_last == (cnt1 == END1)));

  p_last_g2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_level == 2'd2) |-> (o_last == (cnt2 == END2)));

  p_g2_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_lvl == 2'd2) |-> (slot_lvl == 2'd1));

  p_g1_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_lvl == 2'd1) |-> (slot_lvl == 2'd0));

  p_idle_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_lvl == 2'd2) |-> !load);

endmodule

bind tspyr_engine tspyr_engine_chk #(
  .PIX_W (PIX_W),
  .IMG_W (IMG_W),
  .IMG_H (IMG_H)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .o_valid  (o_valid),
  .o_ready  (o_ready),
  .o_pix    (o_pix),
  .o_level  (o_level),
  .o_last   (o_last),
  .slot_lvl (slot_lvl),
  .load     (load),
  .load_lvl (load_lvl)
);

// File: tb/tspyr_engine_bench.sv
module tspyr_engine_bench;

  localparam int W  = 16;
  localparam int H  = 16;
  localparam int W1 = W / 2;
  localparam int H1 = H / 2;
  localparam int W2 = W / 4;
  localparam int H2 = H / 4;
  localparam int N0 = W * H;
  localparam int N1 = W1 * H1;
  localparam int N2 = W2 * H2;
  localparam int WORK = 21;
  localparam int WATCHDOG = 150000;

  logic       clk;
  logic       rst_n;
  logic       i_valid;
  logic       i_ready;
  logic [7:0] i_pix;
  logic       o_valid;
  logic       o_ready;
  logic [7:0] o_pix;
  logic [1:0] o_level;
  logic       o_last;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;

  int src [2][N0];
  int e1  [2][N1];
  int e2  [2][N2];

  tspyr_engine u_tspyr_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .i_ready (i_ready),
    .i_pix   (i_pix),
    .o_valid (o_valid),
    .o_ready (o_ready),
    .o_pix   (o_pix),
    .o_level (o_level),
    .o_last  (o_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int pat_pix(input int p, input int f, input int r, input int c);
    case (p)
      0: return r * 16 + c;
      1: return 200;
      2: return ((r + c) % 2 == 1) ? 255 : 0;
      3: return ((r * 37 + c * 101 + f * 53) * 73 + 11) % 256;
      4: return ((r == 0 && c == 0) || (r == H - 1 && c == W - 1)) ? 255 : 0;
      default: return (c * 17 + r * 3) % 256;
    endcase
  endfunction

  task automatic build_expected(input int p, input int f);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        src[f][r*W+c] = pat_pix(p, f, r, c);
    for (int r1 = 0; r1 < H1; r1++)
      for (int c1 = 0; c1 < W1; c1++) begin
        int s;
        s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            s += ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1) *
                 src[f][clampi(2*r1+dr, H-1)*W + clampi(2*c1+dc, W-1)];
        e1[f][r1*W1+c1] = s / 16;
      end
    for (int r2 = 0; r2 < H2; r2++)
      for (int c2 = 0; c2 < W2; c2++) begin
        int s;
        s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            s += ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1) *
                 e1[f][clampi(2*r2+dr, H1-1)*W1 + clampi(2*c2+dc, W1-1)];
        e2[f][r2*W2+c2] = s / 16;
      end
  endtask

  // drives nfr frames of pattern p and checks every beat of both levels
  task automatic run_frames(input int p, input int nfr, input bit gaps,
                            input bit stalls, input bit chk_slot, input string tag);
    int in_idx, k1, k2, cyc;
    bit prev_hold;
    int prev_pix, prev_lvl, prev_last;
    for (int f = 0; f < nfr; f++) build_expected(p, f);
    in_idx = 0; k1 = 0; k2 = 0; cyc = 0; prev_hold = 0;
    prev_pix = 0; prev_lvl = 0; prev_last = 0;
    while ((k1 < nfr * N1 || k2 < nfr * N2) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      // R5: a stalled beat must still be there, unchanged
      if (prev_hold) begin
        check(o_valid && o_pix == prev_pix && o_level == prev_lvl && o_last == prev_last,
              "R5", {tag, " stalled beat changed"}, int'(o_pix), prev_pix);
      end
      // input side (R6)
      if (in_idx < nfr * N0 && !(gaps && ((cyc * 7 + in_idx) % 5 == 0))) begin
        i_valid = 1'b1;
        i_pix   = 8'(src[in_idx / N0][in_idx % N0]);
      end else begin
        i_valid = 1'b0;
      end
      if (i_valid && i_ready) in_idx++;
      // output side
      o_ready = stalls ? ((cyc % 3) != 0) : 1'b1;
      prev_hold = o_valid && !o_ready;
      prev_pix = int'(o_pix); prev_lvl = int'(o_level); prev_last = int'(o_last);
      if (o_valid && o_ready) begin
        if (o_level == 2'd1 && k1 < nfr * N1) begin
          check(int'(o_pix) == e1[k1 / N1][k1 % N1], "R1", {tag, " G1 pixel"},
                int'(o_pix), e1[k1 / N1][k1 % N1]);
          check(o_last == ((k1 % N1) == N1 - 1), "R4", {tag, " G1 last"},
                int'(o_last), int'((k1 % N1) == N1 - 1));
          if (chk_slot)
            check((edge_cnt - 1) % WORK >= 5, "R7", {tag, " G1 beat slot"},
                  (edge_cnt - 1) % WORK, 5);
          k1++;
        end else if (o_level == 2'd2 && k2 < nfr * N2) begin
          check(int'(o_pix) == e2[k2 / N2][k2 % N2], "R2", {tag, " G2 pixel"},
                int'(o_pix), e2[k2 / N2][k2 % N2]);
          check(o_last == ((k2 % N2) == N2 - 1), "R4", {tag, " G2 last"},
                int'(o_last), int'((k2 % N2) == N2 - 1));
          if (chk_slot)
            check(((edge_cnt - 1) % WORK >= 1) && ((edge_cnt - 1) % WORK <= 4), "R7",
                  {tag, " G2 beat slot"}, (edge_cnt - 1) % WORK, 1);
          k2++;
        end else begin
          check(1'b0, "R3", {tag, " unexpected tag or surplus beat"}, int'(o_level), 1);
        end
      end
    end
    i_valid = 1'b0;
    o_ready = 1'b1;
    check(k1 == nfr * N1, "R8", {tag, " G1 beat count"}, k1, nfr * N1);
    check(k2 == nfr * N2, "R8", {tag, " G2 beat count"}, k2, nfr * N2);
    check(in_idx == nfr * N0, "R6", {tag, " source pixels taken"}, in_idx, nfr * N0);
    // nothing further may appear once the frame is complete (R8)
    begin
      int extra;
      extra = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (o_valid) extra++;
      end
      check(extra == 0, "R8", {tag, " beats after frame end"}, extra, 0);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(o_valid == 1'b0, "R10", "o_valid after reset", int'(o_valid), 0);
    check(i_ready == 1'b1, "R10", "i_ready after reset", int'(i_ready), 1);
  endtask

  task automatic t_ramp_slots();      run_frames(0, 1, 1'b0, 1'b0, 1'b1, "ramp/R7"); endtask
  task automatic t_flat();            run_frames(1, 1, 1'b0, 1'b0, 1'b1, "flat");    endtask
  task automatic t_checker_gaps();    run_frames(2, 1, 1'b1, 1'b0, 1'b0, "checker/R6"); endtask
  task automatic t_corners();         run_frames(4, 1, 1'b0, 1'b0, 1'b1, "corners"); endtask
  task automatic t_noise_stall();     run_frames(3, 1, 1'b1, 1'b1, 1'b0, "noise/R5"); endtask
  task automatic t_two_frames();      run_frames(3, 2, 1'b0, 1'b0, 1'b1, "frames/R9"); endtask
  task automatic t_slope_stall();     run_frames(5, 2, 1'b1, 1'b1, 1'b0, "slope/R9"); endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    i_valid = 1'b0;
    i_pix   = '0;
    o_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(o_valid == 1'b0, "R10", "o_valid during reset", int'(o_valid), 0);
    rst_n = 1'b1;
    t_reset_state();
    t_ramp_slots();
    t_flat();
    t_checker_gaps();
    t_corners();
    t_noise_stall();
    t_two_frames();
    t_slope_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule